// File: doc/BRIEF.md
# Interrupt-Driven Peripheral DMA Channel

This block is one DMA channel attached to the interrupt logic of a peripheral. The channel has a pending flag and an enable flag. When both are set, the channel asks to move one data item. The move happens only at an instruction boundary, only when the channel's priority is at least the CPU's current priority, and never while the top-level interrupt service is running. Each move transfers one item between the peripheral data path and the location held in the channel's address register. The address then steps up by one and the transaction count steps down by one.

The target is either memory or the register file. For memory, the upper address byte comes from one of two sources: the CPU's interrupt-service page input or the channel's own segment register. The direction of the move is set by a peripheral-type input and does not change from one move to the next. When the count reaches zero, the channel clears its own enable and raises an end-of-block flag. That flag is forwarded as an interrupt only while the channel outranks the CPU. If a request is accepted while the count is already zero, no move takes place and the channel goes straight to end-of-block.

Top module: `irq_dma_channel`

## Requirements
- R1: Register writes are decoded by `reg_wr_sel`: 0 = control word, 1 = address, 2 = transaction count, 3 = segment. The control word bits are: bit0 pending, bit1 DMA enable, bit2 end-of-block interrupt enable, bit3 end-of-block flag, bit4 register-file target, bit5 segment select, bits 8:6 channel priority. A register write takes effect on the next clock and wins over any hardware update of the same register in that cycle.
- R2: A transfer is requested only when the pending and enable bits are both set. Pending is set either by a `hw_event` pulse or by a control write.
- R3: A request is accepted only on a cycle where `cpu_instr_end` is high and the channel priority is greater than or equal to `cpu_prio`. After acceptance, `bus_req` rises on the next cycle.
- R4: No request is accepted while `cpu_top_isr` is high.
- R5: `bus_req` stays high, with a stable address, until `bus_gnt` is seen at a clock edge. On that edge the address increments, the count decrements and pending clears. None of these happen on any other cycle.
- R6: When a transfer takes the count from 1 to 0, the enable bit clears and the end-of-block flag sets. After that, further pending events cause no transfer.
- R7: `eob_irq` is high exactly while the end-of-block flag and the end-of-block enable are set and the channel priority is strictly greater than `cpu_prio`. The flag stays set until it is rewritten.
- R8: If a request is accepted while the count is zero, no bus request is made. On that same edge, enable and pending clear and the end-of-block flag sets.
- R9: With the register-file target clear, `bus_space` is 0 and `bus_addr` is {upper byte, address}. With it set, `bus_space` is 1 and `bus_addr` is the low 8 address bits with all upper bits zero.
- R10: For memory targets, the upper address byte is `isr_page` when segment select is 0 and the segment register when it is 1.
- R11: While the register-file target is selected, an address write with a value above 0xDF is ignored.
- R12: With `periph_is_tx` high, transfers read the bus (`bus_we` = 0). The granted read data appears on `periph_tx_data`, and `periph_tx_load` pulses on the cycle after the grant. With it low, transfers write the bus (`bus_we` = 1) with `bus_wdata` = `periph_rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select |
| reg_wr_data | input | 16 | Register write data |
| hw_event | input | 1 | Peripheral event, sets pending |
| cpu_prio | input | 3 | CPU current priority level |
| cpu_instr_end | input | 1 | Instruction boundary |
| cpu_top_isr | input | 1 | Top-level interrupt service active |
| isr_page | input | 8 | Interrupt-service page value |
| periph_is_tx | input | 1 | Peripheral type: 1 = memory to peripheral |
| periph_rx_data | input | 8 | Data from peripheral |
| periph_tx_data | output | 8 | Data to peripheral |
| periph_tx_load | output | 1 | Load strobe for periph_tx_data |
| bus_req | output | 1 | Bus request |
| bus_space | output | 1 | 0 = memory, 1 = register file |
| bus_we | output | 1 | Bus write |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_gnt | input | 1 | Bus grant |
| bus_rdata | input | 8 | Bus read data |
| eob_irq | output | 1 | End-of-block interrupt request |

## Verification
The directed patterns each isolate one cause of a held-off request: enable without pending, CPU priority one above the channel and then equal to it, and the top-level service flag. Each is followed by its release, so a gate that is too strict is caught as well as one that is too loose. A grant that arrives several cycles late shows whether the address and count move before the grant. Separate patterns drive the count down to zero, start with a count of zero, switch between the two upper-address sources, and write an out-of-window register-file address. A long stretch of random priorities, boundaries, events, latencies and register writes then mixes all of these. In that stretch, writes often coincide with grants, which exercises the rule that a write wins over a hardware update.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    localparam int PRIO_W   = 3;
    localparam int RF_AW    = 8;
    localparam int RF_LIMIT = 'hDF;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              ext_seg;
        logic              tgt_rf;
        logic              eob_flag;
        logic              eob_en;
        logic              mask;
        logic              pend;
    } ch_ctrl_t;

    localparam int CTRL_W = $bits(ch_ctrl_t);

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_SEG  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } sched_st_e;

    function automatic logic rf_addr_legal(input logic [31:0] value);
        return value <= 32'(RF_LIMIT);
    endfunction

endpackage

// File: rtl/dmach_sched.sv
module dmach_sched
    import dmach_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_ok,
    input  logic prio_ok,
    input  logic instr_end,
    input  logic top_busy,
    input  logic cnt_zero,
    input  logic bus_gnt,
    output logic xfer_req,
    output logic start_empty,
    output logic commit
);

    sched_st_e st;
    logic      go;

    assign go          = (st == ST_IDLE) && req_ok && prio_ok && instr_end && !top_busy;
    assign start_empty = go && cnt_zero;
    assign commit      = (st == ST_XFER) && bus_gnt;
    assign xfer_req    = (st == ST_XFER);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
        end else begin
            case (st)
                ST_IDLE: if (go && !cnt_zero) st <= ST_XFER;
                ST_XFER: if (bus_gnt)         st <= ST_IDLE;
                default:                      st <= ST_IDLE;
            endcase
        end
    end

    AST_REQ_NEEDS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_req) |-> $past(req_ok)); // R2
    AST_REQ_PRIO_GATE: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_req) |-> $past(prio_ok && instr_end)); // R3
    AST_REQ_NOT_IN_TOP: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_req) |-> $past(!top_busy)); // R4
    AST_HOLD_UNTIL_GNT: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && !bus_gnt) |=> xfer_req); // R5
    AST_EMPTY_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        start_empty |=> !xfer_req); // R8

endmodule

// File: rtl/dmach_regs.sv
module dmach_regs
    import dmach_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int EXT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              hw_event,
    input  logic              commit,
    input  logic              start_empty,
    output ch_ctrl_t          ctrl,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  cnt,
    output logic [EXT_W-1:0]  seg
);

    ch_ctrl_t          ctrl_n;
    logic [ADDR_W-1:0] addr_n;
    logic [CNT_W-1:0]  cnt_n;
    logic [EXT_W-1:0]  seg_n;

    always_comb begin
        ctrl_n = ctrl;
        addr_n = addr;
        cnt_n  = cnt;
        seg_n  = seg;
        if (start_empty) begin
            ctrl_n.mask     = 1'b0;
            ctrl_n.eob_flag = 1'b1;
            ctrl_n.pend     = 1'b0;
        end
        if (commit) begin
            addr_n      = addr + ADDR_W'(1);
            cnt_n       = cnt - CNT_W'(1);
            ctrl_n.pend = 1'b0;
            if (cnt == CNT_W'(1)) begin
                ctrl_n.mask     = 1'b0;
                ctrl_n.eob_flag = 1'b1;
            end
        end
        if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_CTRL: ctrl_n = ch_ctrl_t'(wr_data[CTRL_W-1:0]);
                SEL_ADDR: if (!ctrl.tgt_rf || rf_addr_legal(32'(wr_data))) addr_n = wr_data;
                SEL_CNT:  cnt_n  = wr_data[CNT_W-1:0];
                SEL_SEG:  seg_n  = wr_data[EXT_W-1:0];
                default:  ;
            endcase
        end
        if (hw_event) ctrl_n.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            addr <= '0;
            cnt  <= '0;
            seg  <= '0;
        end else begin
            ctrl <= ctrl_n;
            addr <= addr_n;
            cnt  <= cnt_n;
            seg  <= seg_n;
        end
    end

    AST_COMMIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (commit && !wr_en) |=> (addr == $past(addr) + ADDR_W'(1)) && (cnt == $past(cnt) - CNT_W'(1))); // R5
    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (commit && !wr_en && !hw_event) |=> !ctrl.pend); // R5
    AST_LAST_DISARMS: assert property (@(posedge clk) disable iff (rst)
        (commit && !wr_en && cnt == CNT_W'(1)) |=> (!ctrl.mask && ctrl.eob_flag)); // R6
    AST_RF_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_ADDR && ctrl.tgt_rf && !rf_addr_legal(32'(wr_data)) && !commit)
        |=> $stable(addr)); // R11

endmodule

// File: rtl/dmach_busif.sv
module dmach_busif
    import dmach_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int EXT_W  = 8,
    parameter int DATA_W = 8,
    localparam int BUS_AW = EXT_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tgt_rf,
    input  logic              ext_seg,
    input  logic [ADDR_W-1:0] addr,
    input  logic [EXT_W-1:0]  seg,
    input  logic [EXT_W-1:0]  isr_page,
    input  logic              periph_is_tx,
    input  logic [DATA_W-1:0] periph_rx_data,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              commit,
    output logic [BUS_AW-1:0] bus_addr,
    output logic              bus_space,
    output logic              bus_we,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_load
);

    logic [EXT_W-1:0] upper;

    assign upper     = ext_seg ? seg : isr_page;
    assign bus_addr  = tgt_rf ? {{(BUS_AW-RF_AW){1'b0}}, addr[RF_AW-1:0]} : {upper, addr};
    assign bus_space = tgt_rf;
    assign bus_we    = !periph_is_tx;
    assign bus_wdata = periph_rx_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_load <= 1'b0;
            tx_data <= '0;
        end else begin
            tx_load <= commit && periph_is_tx;
            if (commit && periph_is_tx) tx_data <= bus_rdata;
        end
    end

    AST_TX_PULSE: assert property (@(posedge clk) disable iff (rst)
        (commit && periph_is_tx) |=> (tx_load && tx_data == $past(bus_rdata))); // R12

endmodule

// File: rtl/irq_dma_channel.sv
module irq_dma_channel
    import dmach_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int EXT_W  = 8,
    parameter int DATA_W = 8,
    localparam int BUS_AW = EXT_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_sel,
    input  logic [ADDR_W-1:0] reg_wr_data,
    input  logic              hw_event,
    input  logic [PRIO_W-1:0] cpu_prio,
    input  logic              cpu_instr_end,
    input  logic              cpu_top_isr,
    input  logic [EXT_W-1:0]  isr_page,
    input  logic              periph_is_tx,
    input  logic [DATA_W-1:0] periph_rx_data,
    output logic [DATA_W-1:0] periph_tx_data,
    output logic              periph_tx_load,
    output logic              bus_req,
    output logic              bus_space,
    output logic              bus_we,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              eob_irq
);

    ch_ctrl_t          ctrl;
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  cnt;
    logic [EXT_W-1:0]  seg;
    logic              commit;
    logic              start_empty;

    dmach_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .EXT_W(EXT_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (reg_wr_en),
        .wr_sel      (reg_wr_sel),
        .wr_data     (reg_wr_data),
        .hw_event    (hw_event),
        .commit      (commit),
        .start_empty (start_empty),
        .ctrl        (ctrl),
        .addr        (addr),
        .cnt         (cnt),
        .seg         (seg)
    );

    dmach_sched u_sched (
        .clk         (clk),
        .rst         (rst),
        .req_ok      (ctrl.pend && ctrl.mask),
        .prio_ok     (ctrl.prio >= cpu_prio),
        .instr_end   (cpu_instr_end),
        .top_busy    (cpu_top_isr),
        .cnt_zero    (cnt == '0),
        .bus_gnt     (bus_gnt),
        .xfer_req    (bus_req),
        .start_empty (start_empty),
        .commit      (commit)
    );

    dmach_busif #(.ADDR_W(ADDR_W), .EXT_W(EXT_W), .DATA_W(DATA_W)) u_busif (
        .clk            (clk),
        .rst            (rst),
        .tgt_rf         (ctrl.tgt_rf),
        .ext_seg        (ctrl.ext_seg),
        .addr           (addr),
        .seg            (seg),
        .isr_page       (isr_page),
        .periph_is_tx   (periph_is_tx),
        .periph_rx_data (periph_rx_data),
        .bus_rdata      (bus_rdata),
        .commit         (commit),
        .bus_addr       (bus_addr),
        .bus_space      (bus_space),
        .bus_we         (bus_we),
        .bus_wdata      (bus_wdata),
        .tx_data        (periph_tx_data),
        .tx_load        (periph_tx_load)
    );

    assign eob_irq = ctrl.eob_flag && ctrl.eob_en && (ctrl.prio > cpu_prio);

    AST_EOB_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        $rose(eob_irq) |-> (ctrl.eob_flag && ctrl.eob_en)); // R7

endmodule

// File: tb/tb_irq_dma_channel.sv
`timescale 1ns/1ps
module tb_irq_dma_channel;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en;
    logic [1:0]  reg_wr_sel;
    logic [15:0] reg_wr_data;
    logic        hw_event;
    logic [2:0]  cpu_prio;
    logic        cpu_instr_end;
    logic        cpu_top_isr;
    logic [7:0]  isr_page;
    logic        periph_is_tx;
    logic [7:0]  periph_rx_data;
    logic [7:0]  periph_tx_data;
    logic        periph_tx_load;
    logic        bus_req;
    logic        bus_space;
    logic        bus_we;
    logic [23:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_gnt;
    logic [7:0]  bus_rdata;
    logic        eob_irq;

    int n_checks = 0;
    int n_fail   = 0;
    int gnt_lat  = 0;
    int gwait    = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_dma_channel dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .hw_event(hw_event), .cpu_prio(cpu_prio),
        .cpu_instr_end(cpu_instr_end), .cpu_top_isr(cpu_top_isr), .isr_page(isr_page),
        .periph_is_tx(periph_is_tx), .periph_rx_data(periph_rx_data),
        .periph_tx_data(periph_tx_data), .periph_tx_load(periph_tx_load),
        .bus_req(bus_req), .bus_space(bus_space), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .eob_irq(eob_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit        m_busy, m_pend, m_mask, m_eoben, m_eob, m_rf, m_xs, m_txl;
    bit [2:0]  m_prio;
    bit [15:0] m_addr;
    bit [7:0]  m_cnt, m_seg, m_txd;

    always @(posedge clk) begin : model
        bit go, cm, was_rf;
        if (rst) begin
            m_busy = 0; m_pend = 0; m_mask = 0; m_eoben = 0; m_eob = 0; m_rf = 0;
            m_xs = 0; m_txl = 0; m_prio = 0; m_addr = 0; m_cnt = 0; m_seg = 0; m_txd = 0;
        end else begin
            go = !m_busy && m_pend && m_mask && (m_prio >= cpu_prio) && cpu_instr_end && !cpu_top_isr;
            cm = m_busy && bus_gnt;
            was_rf = m_rf;
            m_txl = cm && periph_is_tx;
            if (cm && periph_is_tx) m_txd = bus_rdata;
            if (go) begin
                if (m_cnt == 0) begin m_mask = 0; m_eob = 1; m_pend = 0; end
                else m_busy = 1;
            end
            if (cm) begin
                m_busy = 0;
                if (m_cnt == 1) begin m_mask = 0; m_eob = 1; end
                m_addr = m_addr + 16'd1;
                m_cnt  = m_cnt - 8'd1;
                m_pend = 0;
            end
            if (reg_wr_en) begin
                case (reg_wr_sel)
                    2'd0: {m_prio, m_xs, m_rf, m_eob, m_eoben, m_mask, m_pend} = reg_wr_data[8:0];
                    2'd1: if (!was_rf || reg_wr_data <= 16'h00DF) m_addr = reg_wr_data;
                    2'd2: m_cnt = reg_wr_data[7:0];
                    default: m_seg = reg_wr_data[7:0];
                endcase
            end
            if (hw_event) m_pend = 1;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin : compare
        logic [23:0] exp_addr;
        if (!rst) begin
            exp_addr = m_rf ? {16'h0000, m_addr[7:0]} : {(m_xs ? m_seg : isr_page), m_addr};
            chk("R3 bus_req", 32'(bus_req), 32'(m_busy));
            chk("R9 bus_space", 32'(bus_space), 32'(m_rf));
            chk("R9 bus_addr", 32'(bus_addr), 32'(exp_addr));
            chk("R12 bus_we", 32'(bus_we), 32'(!periph_is_tx));
            if (m_busy && !periph_is_tx) chk("R12 bus_wdata", 32'(bus_wdata), 32'(periph_rx_data));
            chk("R12 tx_load", 32'(periph_tx_load), 32'(m_txl));
            if (m_txl) chk("R12 tx_data", 32'(periph_tx_data), 32'(m_txd));
            chk("R7 eob_irq", 32'(eob_irq), 32'(m_eob && m_eoben && (m_prio > cpu_prio)));
        end
    end

    // bus responder
    always @(negedge clk) begin
        #1;
        if (bus_req) begin
            bus_gnt = (gwait >= gnt_lat);
            gwait++;
        end else begin
            bus_gnt = 1'b0;
            gwait = 0;
        end
        bus_rdata = bus_addr[7:0] ^ 8'hA5;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic nx();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
        nx();
        reg_wr_en = 1'b0;
    endtask

    task automatic pulse_event();
        hw_event = 1'b1;
        nx();
        hw_event = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 60 && bus_req; i++) nx();
    endtask

    function automatic logic [15:0] cw(input logic [2:0] p, input bit xs, input bit rf,
                                       input bit ef, input bit ee, input bit m, input bit pd);
        return {7'b0, p, xs, rf, ef, ee, m, pd};
    endfunction

    initial begin
        rst = 1'b1; reg_wr_en = 0; reg_wr_sel = 0; reg_wr_data = 0; hw_event = 0;
        cpu_prio = 0; cpu_instr_end = 1; cpu_top_isr = 0; isr_page = 8'h22;
        periph_is_tx = 0; periph_rx_data = 8'h3C; bus_gnt = 0; bus_rdata = 0;
        gnt_lat = 3;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        nx();
        chk("R3 reset bus_req", 32'(bus_req), 32'd0);
        chk("R7 reset eob_irq", 32'(eob_irq), 32'd0);
        chk("R12 reset tx_load", 32'(periph_tx_load), 32'd0);

        // R1: register writes; R2: enable without pending does nothing
        wr(2'd2, 16'd3);
        wr(2'd1, 16'h1000);
        chk("R1 address write", 32'(bus_addr), 32'h221000);
        wr(2'd0, cw(3'd3, 0, 0, 0, 1, 1, 0));
        nx(); nx(); nx();
        chk("R2 no pending no request", 32'(bus_req), 32'd0);
        pulse_event();
        nx();
        chk("R2 event raises request", 32'(bus_req), 32'd1);
        chk("R9 memory address", 32'(bus_addr), 32'h221000);
        // R5: held while grant is late
        nx(); nx();
        chk("R5 request held", 32'(bus_req), 32'd1);
        chk("R5 address stable before grant", 32'(bus_addr), 32'h221000);
        wait_idle();
        chk("R5 address stepped on grant", 32'(bus_addr), 32'h221001);

        // R3: priority gate
        cpu_prio = 3'd4;
        pulse_event();
        nx(); nx();
        chk("R3 lower channel priority blocks", 32'(bus_req), 32'd0);
        cpu_prio = 3'd3;
        nx();
        chk("R3 equal priority accepted", 32'(bus_req), 32'd1);
        wait_idle();

        // R3: boundary required
        cpu_prio = 3'd0; cpu_instr_end = 0;
        pulse_event();
        nx(); nx();
        chk("R3 no boundary no request", 32'(bus_req), 32'd0);
        cpu_instr_end = 1;

        // R4: top-level service blocks
        cpu_top_isr = 1;
        nx(); nx();
        chk("R4 top service blocks", 32'(bus_req), 32'd0);
        cpu_top_isr = 0;
        nx();
        chk("R4 release accepted", 32'(bus_req), 32'd1);
        wait_idle();

        // R6: terminal count
        chk("R6 end-of-block raised", 32'(eob_irq), 32'd1);
        pulse_event();
        nx(); nx(); nx();
        chk("R6 enable cleared", 32'(bus_req), 32'd0);

        // R7: strict priority for end-of-block
        cpu_prio = 3'd3;
        nx();
        chk("R7 equal priority holds interrupt", 32'(eob_irq), 32'd0);
        cpu_prio = 3'd2;
        nx();
        chk("R7 pending interrupt forwarded", 32'(eob_irq), 32'd1);
        wr(2'd0, cw(3'd3, 0, 0, 0, 1, 0, 0));
        chk("R7 flag cleared by write", 32'(eob_irq), 32'd0);

        // R8: zero count at request
        wr(2'd2, 16'd0);
        wr(2'd0, cw(3'd5, 0, 0, 0, 1, 1, 1));
        nx(); nx();
        chk("R8 zero count no bus", 32'(bus_req), 32'd0);
        chk("R8 zero count end-of-block", 32'(eob_irq), 32'd1);

        // R10: upper address source
        wr(2'd3, 16'h007E);
        wr(2'd1, 16'h0400);
        wr(2'd0, cw(3'd5, 1, 0, 0, 0, 0, 0));
        chk("R10 segment source", 32'(bus_addr), 32'h7E0400);
        wr(2'd0, cw(3'd5, 0, 0, 0, 0, 0, 0));
        chk("R10 page source", 32'(bus_addr), 32'h220400);

        // R11: register-file window
        wr(2'd0, cw(3'd5, 0, 1, 0, 0, 0, 0));
        chk("R9 register-file space", 32'(bus_space), 32'd1);
        wr(2'd1, 16'h00D0);
        chk("R11 in-window accepted", 32'(bus_addr), 32'h0000D0);
        wr(2'd1, 16'h00E5);
        chk("R11 out-of-window rejected", 32'(bus_addr), 32'h0000D0);

        // R12: memory-to-peripheral direction
        periph_is_tx = 1;
        gnt_lat = 0;
        wr(2'd2, 16'd2);
        wr(2'd0, cw(3'd5, 0, 1, 0, 1, 1, 1));
        nx();
        chk("R12 read cycle", 32'(bus_we), 32'd0);
        wait_idle();
        chk("R12 load pulse", 32'(periph_tx_load), 32'd1);
        chk("R12 delivered data", 32'(periph_tx_data), 32'(8'hD0 ^ 8'hA5));
        periph_is_tx = 0;

        // random mix, checked by the model every clock
        for (int i = 0; i < 4000; i++) begin
            hw_event      = ($urandom % 6) == 0;
            cpu_prio      = 3'($urandom % 8);
            cpu_instr_end = ($urandom % 3) != 0;
            cpu_top_isr   = ($urandom % 7) == 0;
            isr_page      = 8'($urandom);
            periph_rx_data = 8'($urandom);
            gnt_lat       = int'($urandom % 4);
            if ((i % 250) == 0) periph_is_tx = 1'($urandom % 2);
            reg_wr_en     = ($urandom % 9) == 0;
            reg_wr_sel    = 2'($urandom % 4);
            if (reg_wr_sel == 2'd2)      reg_wr_data = 16'($urandom % 4);
            else if (reg_wr_sel == 2'd1) reg_wr_data = (($urandom % 2) == 0) ? 16'($urandom % 256) : 16'($urandom);
            else if (reg_wr_sel == 2'd0) reg_wr_data = 16'($urandom % 512) | 16'h0002;
            else                         reg_wr_data = 16'($urandom);
            nx();
        end
        reg_wr_en = 0; hw_event = 0;
        repeat (6) nx();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule